// File: doc/BRIEF.md
# SMBus Line-State Supervisor

This block sits beside the byte-level engine of an SMBus slave and watches only the levels of the clock and data wires. Each wire first passes through a two-flop synchronizer and a short glitch filter. Timers driven by a slow timebase tick then measure how long the lines stay low. A single clock-low period that runs too long aborts the transaction in progress. Both lines held low for a long time put the bus into an off state. An even longer hold of both lines asks for an offset calibration, once per episode.

While a transaction is open (between the start and stop indications from the protocol engine), two accumulators add up clock-low time. One counts time the local slave spends stretching the clock. The other counts time the master spends extending it. Each raises a sticky error when it passes its budget. A start that follows a stop too soon is flagged as a bus-free-time violation.

All limits are parameters counted in timebase ticks. The defaults assume a 10 µs tick. A bench can shrink the limits to a few ticks.

Top module: `smb_line_supervisor`

## Requirements
- R1: While a transaction is open, a filtered clock-low period that lasts `TO_TICKS` ticks produces exactly one `abort_o` pulse and closes the transaction. A clock-low period outside a transaction produces no pulse.
- R2: `bus_off_o` rises once both filtered lines have been low together for `OFF_TICKS` ticks. It stays low for any shorter joint-low episode.
- R3: `bus_off_o` falls on the clock after either filtered line is seen high.
- R4: `bus_ready_o` is low whenever `bus_off_o` is high. It returns high `RDY_TICKS` ticks after the bus-off state ends. The default of 50 ticks is 0.5 ms, which is within 1 ms. It is high after reset.
- R5: `cal_req_o` gives a one-cycle pulse when a joint-low episode reaches `CAL_TICKS` ticks (`CAL_TICKS` > `OFF_TICKS`). It gives only one pulse per episode, however long the episode lasts. It re-arms once either line goes high.
- R6: Inside a transaction, the ticks during which the clock is low while `slv_hold_i` is set are summed. `slv_ext_err_o` sets when the sum exceeds `SLV_EXT_TICKS`. It stays set until the next `xfer_start_i`.
- R7: Inside a transaction, the ticks during which the clock is low while `mst_ext_i` is set are summed. `mst_ext_err_o` sets when the sum exceeds `MST_EXT_TICKS`. It stays set until the next `xfer_start_i`.
- R8: An `xfer_start_i` arriving fewer than `FREE_TICKS` ticks after the last `xfer_stop_i` produces one `early_start_o` pulse. The first start after reset is never early.
- R9: A level change on either wire that lasts fewer than `FILT_LEN` clock cycles after synchronization is ignored. A one-cycle blip does not restart the joint-low timer.
- R10: After reset, `abort_o`, `bus_off_o`, `cal_req_o`, both extension errors and `early_start_o` are 0, and `bus_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle timebase strobe; all limits count these |
| scl_i | input | 1 | Raw clock wire level |
| sda_i | input | 1 | Raw data wire level |
| xfer_start_i | input | 1 | Start condition seen by the protocol engine (pulse) |
| xfer_stop_i | input | 1 | Stop condition seen by the protocol engine (pulse) |
| slv_hold_i | input | 1 | Local slave is holding the clock low |
| mst_ext_i | input | 1 | Master is extending its clock-low phase |
| abort_o | output | 1 | One-cycle abort of the open transaction |
| bus_off_o | output | 1 | Bus-off state |
| bus_ready_o | output | 1 | Bus available for traffic |
| cal_req_o | output | 1 | One-cycle offset calibration request |
| slv_ext_err_o | output | 1 | Sticky slave stretch budget error |
| mst_ext_err_o | output | 1 | Sticky master extension budget error |
| early_start_o | output | 1 | One-cycle bus-free-time violation |

## Verification
The bound checker watches a set of relations on every cycle:
- A bus-off rise only follows joint-low filtered lines.
- Bus-off falls on the cycle after either filtered line goes high.
- The ready flag never overlaps bus-off.
- The calibration pulse is single-cycle and only occurs inside bus-off.
- An abort always leaves the transaction closed.
- Error flags rise only inside transactions and clear only at a start.

Only the bench scenarios can show the parts that depend on elapsed time. These are where each tick threshold falls, the once-per-episode behaviour of the calibration request over a long hold, its re-arming, the rejection of a one-cycle glitch, and the ready delay after release.

// File: rtl/smb_sup_pkg.sv
package smb_sup_pkg;

  // Counter width able to hold 0..sat
  function automatic int unsigned cnt_width(input int unsigned sat);
    return (sat < 1) ? 1 : $clog2(sat + 1);
  endfunction

  // True when the next tick step lands a counter exactly on lim
  function automatic logic last_step(input int unsigned cnt, input int unsigned lim);
    return (cnt + 1 == lim);
  endfunction

  // True while a counter is still short of lim
  function automatic logic below(input int unsigned cnt, input int unsigned lim);
    return (cnt < lim);
  endfunction

endpackage

// File: rtl/smb_sup_filter.sv
module smb_sup_filter #(
  parameter int unsigned FILT_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic filt_o
);
  localparam int unsigned CW = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN);
  localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

  logic          s1_q, s2_q;
  logic [CW-1:0] run_q;

  // two-flop synchronizer; idle bus level is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= raw_i;
      s2_q <= s1_q;
    end
  end

  // accept a new level only after FILT_LEN consecutive differing samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_o <= 1'b1;
      run_q  <= '0;
    end else if (s2_q == filt_o) begin
      run_q <= '0;
    end else if (run_q == LAST) begin
      filt_o <= s2_q;
      run_q  <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/smb_sup_tickcnt.sv
module smb_sup_tickcnt #(
  parameter int unsigned SAT      = 1,
  parameter bit          RST_FULL = 1'b0,
  parameter int unsigned W        = smb_sup_pkg::cnt_width(SAT)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         en_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] SAT_V = W'(SAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              cnt_o <= RST_FULL ? SAT_V : '0;
    else if (clr_i)                           cnt_o <= '0;
    else if (tick_i && en_i && cnt_o != SAT_V) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/smb_line_supervisor.sv
module smb_line_supervisor #(
  parameter int unsigned FILT_LEN      = 4,
  parameter int unsigned TO_TICKS      = 3000,
  parameter int unsigned OFF_TICKS     = 200000,
  parameter int unsigned CAL_TICKS     = 500000,
  parameter int unsigned SLV_EXT_TICKS = 2500,
  parameter int unsigned MST_EXT_TICKS = 1000,
  parameter int unsigned FREE_TICKS    = 1,
  parameter int unsigned RDY_TICKS     = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic scl_i,
  input  logic sda_i,
  input  logic xfer_start_i,
  input  logic xfer_stop_i,
  input  logic slv_hold_i,
  input  logic mst_ext_i,
  output logic abort_o,
  output logic bus_off_o,
  output logic bus_ready_o,
  output logic cal_req_o,
  output logic slv_ext_err_o,
  output logic mst_ext_err_o,
  output logic early_start_o
);
  import smb_sup_pkg::*;

  localparam int unsigned NLINE   = 2;
  localparam int unsigned SLV_LIM = SLV_EXT_TICKS + 1;
  localparam int unsigned MST_LIM = MST_EXT_TICKS + 1;
  localparam int unsigned W_LOW   = cnt_width(TO_TICKS);
  localparam int unsigned W_BOTH  = cnt_width(CAL_TICKS);
  localparam int unsigned W_SLV   = cnt_width(SLV_LIM);
  localparam int unsigned W_MST   = cnt_width(MST_LIM);
  localparam int unsigned W_FREE  = cnt_width(FREE_TICKS);
  localparam int unsigned W_RDY   = cnt_width(RDY_TICKS);

  // ---------------- input conditioning ----------------
  logic [NLINE-1:0] raw_lines;
  logic [NLINE-1:0] filt_lines;
  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < NLINE; g++) begin : g_line
    smb_sup_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (raw_lines[g]),
      .filt_o (filt_lines[g])
    );
  end

  logic scl_f, sda_f, both_low;
  assign scl_f    = filt_lines[0];
  assign sda_f    = filt_lines[1];
  assign both_low = ~scl_f & ~sda_f;

  // ---------------- state registers ----------------
  logic in_xfer;
  logic bus_off_q;

  // ---------------- tick counters ----------------
  logic [W_LOW-1:0]  low_cnt;
  logic [W_BOTH-1:0] both_cnt;
  logic [W_SLV-1:0]  slv_cnt;
  logic [W_MST-1:0]  mst_cnt;
  logic [W_FREE-1:0] free_cnt;
  logic [W_RDY-1:0]  rdy_cnt;
  logic slv_en, mst_en;

  assign slv_en = in_xfer & slv_hold_i & ~scl_f;
  assign mst_en = in_xfer & mst_ext_i & ~scl_f;

  smb_sup_tickcnt #(.SAT(TO_TICKS)) u_low_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .en_i(~scl_f), .clr_i(scl_f), .cnt_o(low_cnt));

  smb_sup_tickcnt #(.SAT(CAL_TICKS)) u_both_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .en_i(both_low), .clr_i(~both_low), .cnt_o(both_cnt));

  smb_sup_tickcnt #(.SAT(SLV_LIM)) u_slv_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .en_i(slv_en), .clr_i(xfer_start_i), .cnt_o(slv_cnt));

  smb_sup_tickcnt #(.SAT(MST_LIM)) u_mst_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .en_i(mst_en), .clr_i(xfer_start_i), .cnt_o(mst_cnt));

  smb_sup_tickcnt #(.SAT(FREE_TICKS), .RST_FULL(1'b1)) u_free_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .en_i(1'b1), .clr_i(xfer_stop_i), .cnt_o(free_cnt));

  smb_sup_tickcnt #(.SAT(RDY_TICKS), .RST_FULL(1'b1)) u_rdy_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .en_i(1'b1), .clr_i(bus_off_q), .cnt_o(rdy_cnt));

  // ---------------- named events ----------------
  logic to_evt, off_evt, cal_evt, slv_evt, mst_evt, early_evt;

  assign to_evt    = tick_i & ~scl_f  & last_step(32'(low_cnt),  TO_TICKS);
  assign off_evt   = tick_i & both_low & last_step(32'(both_cnt), OFF_TICKS);
  assign cal_evt   = tick_i & both_low & last_step(32'(both_cnt), CAL_TICKS);
  assign slv_evt   = tick_i & slv_en & ~xfer_start_i & last_step(32'(slv_cnt), SLV_LIM);
  assign mst_evt   = tick_i & mst_en & ~xfer_start_i & last_step(32'(mst_cnt), MST_LIM);
  assign early_evt = xfer_start_i & below(32'(free_cnt), FREE_TICKS);

  // ---------------- registered outputs ----------------
  logic abort_q, cal_q, slv_err_q, mst_err_q, early_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_xfer   <= 1'b0;
      abort_q   <= 1'b0;
      bus_off_q <= 1'b0;
      cal_q     <= 1'b0;
      slv_err_q <= 1'b0;
      mst_err_q <= 1'b0;
      early_q   <= 1'b0;
    end else begin
      abort_q <= to_evt & in_xfer & ~xfer_start_i;
      cal_q   <= cal_evt;
      early_q <= early_evt;

      if (xfer_start_i)                 in_xfer <= 1'b1;
      else if (xfer_stop_i || to_evt)   in_xfer <= 1'b0;

      if (!both_low)    bus_off_q <= 1'b0;
      else if (off_evt) bus_off_q <= 1'b1;

      if (xfer_start_i) slv_err_q <= 1'b0;
      else if (slv_evt) slv_err_q <= 1'b1;

      if (xfer_start_i) mst_err_q <= 1'b0;
      else if (mst_evt) mst_err_q <= 1'b1;
    end
  end

  assign abort_o       = abort_q;
  assign bus_off_o     = bus_off_q;
  assign bus_ready_o   = ~bus_off_q & (rdy_cnt == W_RDY'(RDY_TICKS));
  assign cal_req_o     = cal_q;
  assign slv_ext_err_o = slv_err_q;
  assign mst_ext_err_o = mst_err_q;
  assign early_start_o = early_q;
endmodule

// File: rtl/smb_line_supervisor_chk.sv
module smb_line_supervisor_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_f,
  input logic sda_f,
  input logic in_xfer,
  input logic xfer_start_i,
  input logic abort_o,
  input logic bus_off_o,
  input logic bus_ready_o,
  input logic cal_req_o,
  input logic slv_ext_err_o,
  input logic mst_ext_err_o,
  input logic early_start_o
);
  a_r1_abort_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> !in_xfer);
  a_r2_off_needs_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_off_o) |-> $past(!scl_f && !sda_f));
  a_r3_off_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_f || sda_f) |=> !bus_off_o);
  a_r4_ready_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_off_o |-> !bus_ready_o);
  a_r5_cal_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_req_o |=> !cal_req_o);
  a_r5_cal_in_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_req_o |-> bus_off_o);
  a_r6_slv_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(slv_ext_err_o) |-> $past(in_xfer));
  a_r6_slv_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(slv_ext_err_o) |-> $past(xfer_start_i));
  a_r7_mst_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mst_ext_err_o) |-> $past(in_xfer));
  a_r7_mst_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mst_ext_err_o) |-> $past(xfer_start_i));
  a_r8_early_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    early_start_o |-> $past(xfer_start_i));
endmodule

bind smb_line_supervisor smb_line_supervisor_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .scl_f         (scl_f),
  .sda_f         (sda_f),
  .in_xfer       (in_xfer),
  .xfer_start_i  (xfer_start_i),
  .abort_o       (abort_o),
  .bus_off_o     (bus_off_o),
  .bus_ready_o   (bus_ready_o),
  .cal_req_o     (cal_req_o),
  .slv_ext_err_o (slv_ext_err_o),
  .mst_ext_err_o (mst_ext_err_o),
  .early_start_o (early_start_o)
);

// File: tb/smb_line_supervisor_tb_top.sv
`timescale 1ns/1ps
module smb_line_supervisor_tb_top;
  localparam int TDIV = 4;
  localparam int TO = 10, OFF = 30, CAL = 50, SLV = 12, MST = 6, FREE = 3, RDY = 4;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic scl = 1'b1, sda = 1'b1, start = 1'b0, stop = 1'b0, shold = 1'b0, mext = 1'b0;
  logic abort_w, off_w, rdy_w, cal_w, serr_w, merr_w, early_w;

  int n_chk = 0, n_fail = 0, n_abort = 0, n_cal = 0, n_early = 0, div = 0;
  bit done = 0;

  always #5 clk = ~clk;

  always @(negedge clk) begin
    div  <= (div == TDIV - 1) ? 0 : div + 1;
    tick <= (div == TDIV - 1);
    if (rst_n) begin
      if (abort_w) n_abort <= n_abort + 1;
      if (cal_w)   n_cal   <= n_cal + 1;
      if (early_w) n_early <= n_early + 1;
    end
  end

  smb_line_supervisor #(
    .FILT_LEN(2), .TO_TICKS(TO), .OFF_TICKS(OFF), .CAL_TICKS(CAL),
    .SLV_EXT_TICKS(SLV), .MST_EXT_TICKS(MST), .FREE_TICKS(FREE), .RDY_TICKS(RDY)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .scl_i(scl), .sda_i(sda),
    .xfer_start_i(start), .xfer_stop_i(stop), .slv_hold_i(shold), .mst_ext_i(mext),
    .abort_o(abort_w), .bus_off_o(off_w), .bus_ready_o(rdy_w), .cal_req_o(cal_w),
    .slv_ext_err_o(serr_w), .mst_ext_err_o(merr_w), .early_start_o(early_w)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n * TDIV) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk) stop = 1'b1;
    @(negedge clk) stop = 1'b0;
  endtask

  // expected abort for a clock-low hold of len ticks (margin of 2 ticks vs filter skew)
  function automatic int exp_abort(input int len);
    return (len >= TO + 2) ? 1 : 0;
  endfunction

  // clock-low chunk of 4 ticks with an optional stretch qualifier
  task automatic chunk(input bit s, input bit m);
    @(negedge clk) begin scl = 1'b0; shold = s; mext = m; end
    wt(4);
    @(negedge clk) begin scl = 1'b1; shold = 1'b0; mext = 1'b0; end
    wt(2);
  endtask

  initial begin : main
    int exp_ab;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 abort", abort_w, 0);
    check("R10 bus_off", off_w, 0);
    check("R10 bus_ready", rdy_w, 1);
    check("R10 cal_req", cal_w, 0);
    check("R10 errs", serr_w + merr_w + early_w, 0);

    // R1 directed: short low, long low, low outside transaction
    pulse_start();
    check("R8 first start not early", n_early, 0);
    @(negedge clk) scl = 1'b0; wt(7); @(negedge clk) scl = 1'b1; wt(3);
    check("R1 short low", n_abort, 0);
    @(negedge clk) scl = 1'b0; wt(14); @(negedge clk) scl = 1'b1; wt(2);
    check("R1 long low aborts", n_abort, 1);
    pulse_stop(); wt(5);
    @(negedge clk) scl = 1'b0; wt(14); @(negedge clk) scl = 1'b1; wt(2);
    check("R1 no transaction", n_abort, 1);

    // R1 constrained random
    exp_ab = n_abort;
    for (int i = 0; i < 10; i++) begin
      int len;
      len = ($urandom_range(1, 0) == 1) ? int'($urandom_range(20, 13)) : int'($urandom_range(7, 2));
      exp_ab += exp_abort(len);
      pulse_start();
      @(negedge clk) scl = 1'b0; wt(len); @(negedge clk) scl = 1'b1; wt(2);
      pulse_stop(); wt(5);
    end
    check("R1 random holds", n_abort, exp_ab);
    check("R8 spaced starts not early", n_early, 0);

    // R8 bus free time
    pulse_start(); pulse_stop(); wt(1); pulse_start(); wt(1);
    check("R8 early start", n_early, 1);
    pulse_stop(); wt(6); pulse_start(); wt(1);
    check("R8 late start", n_early, 1);

    // R6 slave stretch budget (transaction open)
    chunk(1, 0); chunk(1, 0);
    check("R6 under budget", serr_w, 0);
    chunk(1, 0); chunk(1, 0); chunk(1, 0);
    check("R6 over budget", serr_w, 1);
    check("R7 untouched by slave stretch", merr_w, 0);
    pulse_stop(); wt(5); pulse_start(); @(negedge clk);
    check("R6 cleared by start", serr_w, 0);

    // R7 master extension budget
    chunk(0, 1);
    check("R7 under budget", merr_w, 0);
    chunk(0, 1); chunk(0, 1);
    check("R7 over budget", merr_w, 1);
    pulse_stop(); wt(5); pulse_start(); @(negedge clk);
    check("R7 cleared by start", merr_w, 0);
    pulse_stop(); wt(5);
    check("R1 chunks never abort", n_abort, exp_ab);

    // R2 short joint-low episode
    @(negedge clk) begin scl = 1'b0; sda = 1'b0; end
    wt(26);
    check("R2 not off before limit", off_w, 0);
    @(negedge clk) begin scl = 1'b1; sda = 1'b1; end
    wt(2);

    // R9 glitch does not restart the joint-low timer; R2 off reached
    @(negedge clk) begin scl = 1'b0; sda = 1'b0; end
    wt(20);
    @(negedge clk) sda = 1'b1;
    @(negedge clk) sda = 1'b0;
    wt(14);
    check("R9 glitch ignored / R2 off", off_w, 1);
    check("R4 not ready in off", rdy_w, 0);
    check("R5 no cal yet", n_cal, 0);
    wt(22);
    check("R5 cal once", n_cal, 1);
    wt(30);
    check("R5 still once", n_cal, 1);
    @(negedge clk) sda = 1'b1;
    wt(2);
    check("R3 off cleared", off_w, 0);
    check("R4 ready delayed", rdy_w, 0);
    wt(RDY + 2);
    check("R4 ready back", rdy_w, 1);

    // R5 re-arm on a new episode
    @(negedge clk) sda = 1'b0;
    wt(56);
    check("R5 rearmed", n_cal, 2);
    check("R1 no abort outside xfer", n_abort, exp_ab);
    @(negedge clk) begin scl = 1'b1; sda = 1'b1; end
    wt(4);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule